// File: doc/BRIEF.md
# Multicast Hash Receive Address Filter

This block sits at the front of an Ethernet receive path and decides, frame by frame, whether a destination address is wanted. It holds a 48-bit station address and a 64-bin logical-address table. The destination address enters one byte per cycle, first byte first. The block gives back one accept/reject result per frame.

An individual address, meaning bit 0 of the first byte is 0, passes only on an exact match with the station address. A group address is hashed. The block runs a reflected CRC-32 over the 48 address bits. It takes the top six bits of the result as a bin number and accepts the frame when that bin is set in the table.

Software loads both tables through a byte-wide configuration port. Each table has its own load pointer that advances on every write. Loading is gated by an address-change control register. A promiscuous mode accepts every frame. A receive-enable bit, dropped automatically on every filter change, blocks all acceptance until software sets it again.

Top module: `mcast_rx_filter`

## Requirements
- R1: After reset, acc_valid, acc and rx_en are 0, promiscuous mode is off, and the station address and the table are all zeros.
- R2: A frame whose first byte has bit 0 clear is accepted only when all six bytes equal the station address. The k-th station byte loaded (k = 0..5) is compared with the k-th byte received.
- R3: For a frame whose first byte has bit 0 set, a CRC register preset to 0xFFFFFFFF is shifted right over the 48 bits, each byte least-significant bit first. Whenever the bit leaving the register differs from the data bit, the register is XORed with 0xEDB88320. The hash index is CRC bits 31..26. Index bits 5..4 pick a 16-bit table word and bits 3..0 the bit in it, with the low byte of each word loaded first. The frame is accepted when table bit (index) is set, that bit being bit index%8 of the (index/8)-th table byte loaded.
- R4: The configuration port is addressed by cfg_sel: 0 control, 1 station data, 2 table data, 3 mode. A table data write is taken only while control bit 0 (address change) and bit 1 (table reset) are both set. Any control write with bit 1 set returns the table pointer to byte 0. The pointer wraps after eight bytes.
- R5: A station data write is taken only while control bit 0 and bit 2 (station reset) are both set. Any control write with bit 2 set returns the station pointer to byte 0. The pointer wraps after six bytes.
- R6: A write to either data port while control bit 0 is clear changes neither table and leaves rx_en unchanged.
- R7: Mode register bit 1 is promiscuous mode and bit 0 is receive enable. With both in effect, every frame is accepted, including a group address whose table bit is clear.
- R8: A data write that is taken, or a mode write that changes the promiscuous bit, clears rx_en. While rx_en is 0 every frame is rejected. A mode write that keeps the promiscuous bit loads rx_en from bit 0.
- R9: acc_valid rises on the second rising edge counted from the edge that samples the sixth address byte. It is 0 one edge earlier. acc_valid and acc then hold until an edge that samples da_valid with da_first.
- R10: A table of eight 0xFF bytes accepts every group address, while individual addresses still need a station match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 station data, 2 table data, 3 mode |
| cfg_wdata | input | 8 | Configuration write byte |
| da_valid | input | 1 | Destination address byte present |
| da_first | input | 1 | Marks the first byte of a frame |
| da_byte | input | 8 | Destination address byte |
| acc_valid | output | 1 | Result for the last frame is present |
| acc | output | 1 | 1 = accept, 0 = reject |
| rx_en | output | 1 | Current receive-enable state |

## Verification
The assertions assume that each frame starts with a byte marked da_first and that its next five address bytes follow in consecutive cycles. They also assume that a new frame does not start in the cycle the previous result is being registered. The latency and hold properties depend on that spacing. Every bench frame drives six bytes back to back with the first one flagged. After the last byte, the bench waits for the result before any further stimulus. Configuration writes are never overlapped with address bytes, so no result depends on a table changing mid-frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [1:0] SEL_CTRL    = 2'd0;
    localparam logic [1:0] SEL_STATION = 2'd1;
    localparam logic [1:0] SEL_TABLE   = 2'd2;
    localparam logic [1:0] SEL_MODE    = 2'd3;

    localparam int CTRL_CHG  = 0;
    localparam int CTRL_LRST = 1;
    localparam int CTRL_PRST = 2;
    localparam int MODE_EN   = 0;
    localparam int MODE_PROM = 1;

    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // Reflected CRC-32 advance over one byte, LSB first
    function automatic logic [31:0] crc_step8(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_BYTES  = 8,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int TBL_W  = 8 * TBL_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] station,
    output logic [TBL_W-1:0]  table_bits,
    output logic              promisc,
    output logic              rx_en,
    output logic              chg,
    output logic              lrst,
    output logic              prst
);
    localparam int LP_W = (TBL_BYTES  > 1) ? $clog2(TBL_BYTES)  : 1;
    localparam int PP_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef struct packed {
        logic              chg;
        logic              lrst;
        logic              prst;
        logic              promisc;
        logic              en;
        logic [LP_W-1:0]   lptr;
        logic [PP_W-1:0]   pptr;
        logic [ADDR_W-1:0] sta;
        logic [TBL_W-1:0]  tbl;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    s_d.chg  = wdata[CTRL_CHG];
                    s_d.lrst = wdata[CTRL_LRST];
                    s_d.prst = wdata[CTRL_PRST];
                    if (wdata[CTRL_LRST]) s_d.lptr = '0;
                    if (wdata[CTRL_PRST]) s_d.pptr = '0;
                end
                SEL_STATION: begin
                    if (s_q.chg && s_q.prst) begin
                        s_d.sta[8*s_q.pptr +: 8] = wdata;
                        s_d.pptr = (s_q.pptr == PP_W'(ADDR_BYTES-1)) ? '0 : s_q.pptr + 1'b1;
                        s_d.en   = 1'b0;
                    end
                end
                SEL_TABLE: begin
                    if (s_q.chg && s_q.lrst) begin
                        s_d.tbl[8*s_q.lptr +: 8] = wdata;
                        s_d.lptr = (s_q.lptr == LP_W'(TBL_BYTES-1)) ? '0 : s_q.lptr + 1'b1;
                        s_d.en   = 1'b0;
                    end
                end
                default: begin
                    if (wdata[MODE_PROM] != s_q.promisc) begin
                        s_d.promisc = wdata[MODE_PROM];
                        s_d.en      = 1'b0;
                    end else begin
                        s_d.en = wdata[MODE_EN];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign station    = s_q.sta;
    assign table_bits = s_q.tbl;
    assign promisc    = s_q.promisc;
    assign rx_en      = s_q.en;
    assign chg        = s_q.chg;
    assign lrst       = s_q.lrst;
    assign prst       = s_q.prst;
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [7:0]        da_byte,
    input  logic [ADDR_W-1:0] station,
    output logic              done,
    output logic [IDX_W-1:0]  idx,
    output logic              match,
    output logic              group
);
    typedef struct packed {
        logic [31:0]      crc;
        logic [CNT_W-1:0] cnt;
        logic             match;
        logic             group;
        logic             done;
    } hs_t;

    hs_t h_d, h_q;

    always_comb begin
        h_d      = h_q;
        h_d.done = 1'b0;
        if (da_valid && da_first) begin
            h_d.crc   = crc_step8(CRC_PRESET, da_byte);
            h_d.cnt   = CNT_W'(1);
            h_d.match = (da_byte == station[7:0]);
            h_d.group = da_byte[0];
            h_d.done  = (ADDR_BYTES == 1);
        end else if (da_valid && h_q.cnt != '0 && h_q.cnt < CNT_W'(ADDR_BYTES)) begin
            h_d.crc   = crc_step8(h_q.crc, da_byte);
            h_d.cnt   = h_q.cnt + 1'b1;
            h_d.match = h_q.match && (da_byte == station[8*h_q.cnt +: 8]);
            h_d.done  = (h_q.cnt == CNT_W'(ADDR_BYTES-1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign done  = h_q.done;
    assign idx   = h_q.crc[31 -: IDX_W];
    assign match = h_q.match;
    assign group = h_q.group;
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
    parameter int TBL_W = 64,
    localparam int IDX_W = $clog2(TBL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [IDX_W-1:0] idx,
    input  logic             match,
    input  logic             group,
    input  logic [TBL_W-1:0] table_bits,
    input  logic             promisc,
    input  logic             rx_en,
    input  logic             frame_start,
    output logic             acc_valid,
    output logic             acc
);
    typedef struct packed {
        logic vld;
        logic acc;
    } dec_t;

    dec_t d_d, d_q;
    logic hit;

    always_comb begin
        hit = group ? table_bits[idx] : match;
        d_d = d_q;
        if (done) begin
            d_d.vld = 1'b1;
            d_d.acc = rx_en && (promisc || hit);
        end else if (frame_start) begin
            d_d.vld = 1'b0;
            d_d.acc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign acc_valid = d_q.vld;
    assign acc       = d_q.acc;
endmodule

// File: rtl/mcast_rx_filter.sv
module mcast_rx_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_BYTES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       da_valid,
    input  logic       da_first,
    input  logic [7:0] da_byte,
    output logic       acc_valid,
    output logic       acc,
    output logic       rx_en
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int TBL_W  = 8 * TBL_BYTES;
    localparam int IDX_W  = $clog2(TBL_W);

    logic [ADDR_W-1:0] station;
    logic [TBL_W-1:0]  table_bits;
    logic              promisc_w;
    logic              ctl_chg, ctl_lrst, ctl_prst;
    logic              h_done, h_match, h_group;
    logic [IDX_W-1:0]  h_idx;

    rxf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .TBL_BYTES(TBL_BYTES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .station(station), .table_bits(table_bits), .promisc(promisc_w),
        .rx_en(rx_en), .chg(ctl_chg), .lrst(ctl_lrst), .prst(ctl_prst)
    );

    rxf_crc_hash #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_hash (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first),
        .da_byte(da_byte), .station(station), .done(h_done), .idx(h_idx),
        .match(h_match), .group(h_group)
    );

    rxf_decide #(.TBL_W(TBL_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .done(h_done), .idx(h_idx), .match(h_match),
        .group(h_group), .table_bits(table_bits), .promisc(promisc_w), .rx_en(rx_en),
        .frame_start(da_valid && da_first), .acc_valid(acc_valid), .acc(acc)
    );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int NB = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] cfg_sel,
    input logic [7:0] cfg_wdata,
    input logic       da_valid,
    input logic       da_first,
    input logic       acc_valid,
    input logic       acc,
    input logic       rx_en,
    input logic       chg,
    input logic       lrst,
    input logic       prst,
    input logic       promisc
);
    localparam int CW = $clog2(NB + 2);
    logic [CW-1:0] seen;
    logic          last_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         seen <= '0;
        else if (da_valid && da_first)      seen <= CW'(1);
        else if (da_valid && seen != '0 && seen < CW'(NB)) seen <= seen + 1'b1;
    end

    assign last_byte = da_valid && !da_first && (seen == CW'(NB-1));

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> ##1 acc_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !(da_valid && da_first) |=> acc_valid && $stable(acc));

    p_accept_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_valid) && acc |-> $past(rx_en));

    p_station_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == SEL_STATION && chg && prst |=> !rx_en);

    p_table_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == SEL_TABLE && chg && lrst |=> !rx_en);

    p_promisc_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_sel == SEL_MODE && cfg_wdata[MODE_PROM] != promisc |=> !rx_en);

    p_ignored_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_sel == SEL_STATION || cfg_sel == SEL_TABLE) && !chg |=> $stable(rx_en));
endmodule

bind mcast_rx_filter rxf_checker #(.NB(ADDR_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .da_valid(da_valid), .da_first(da_first), .acc_valid(acc_valid), .acc(acc),
    .rx_en(rx_en), .chg(ctl_chg), .lrst(ctl_lrst), .prst(ctl_prst), .promisc(promisc_w)
);

// File: tb/mcast_rx_filter_tb.sv
module mcast_rx_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] T_CTRL = 2'd0, T_STA = 2'd1, T_TBL = 2'd2, T_MODE = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic da_valid = 1'b0, da_first = 1'b0;
    logic [7:0] da_byte = '0;
    logic acc_valid, acc, rx_en;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic got_vld, got_acc, early_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_rx_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
        .acc_valid(acc_valid), .acc(acc), .rx_en(rx_en)
    );

    function automatic logic [47:0] mac(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic int hash_idx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            logic fb;
            fb = c[0] ^ a[k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return int'(c >> 26);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_station(input logic [47:0] a);
        cfg_write(T_CTRL, 8'h05);
        for (int k = 0; k < 6; k++) cfg_write(T_STA, a[8*k +: 8]);
        cfg_write(T_CTRL, 8'h00);
    endtask

    task automatic load_table(input logic [63:0] t);
        cfg_write(T_CTRL, 8'h03);
        for (int k = 0; k < 8; k++) cfg_write(T_TBL, t[8*k +: 8]);
        cfg_write(T_CTRL, 8'h00);
    endtask

    task automatic set_mode(input logic en, input logic prom);
        cfg_write(T_MODE, {6'b0, prom, en});
    endtask

    task automatic send_frame(input logic [47:0] a);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            da_valid = 1'b1; da_first = (k == 0); da_byte = a[8*k +: 8];
        end
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0;
        early_vld = acc_valid;
        @(posedge clk);
        @(negedge clk);
        got_vld = acc_valid; got_acc = acc;
    endtask

    logic [47:0] sta_a, oth_a, g1, g2;
    int i1, i2;

    task automatic t_reset;
        check("R1 acc_valid", acc_valid, 0);
        check("R1 acc", acc, 0);
        check("R1 rx_en", rx_en, 0);
        set_mode(1'b1, 1'b0);
        check("R8 mode enable", rx_en, 1);
        send_frame(48'h0);
        check("R1 zero station match", {got_vld, got_acc}, 2'b11);
    endtask

    task automatic t_station;
        load_station(sta_a);
        check("R8 station write clears en", rx_en, 0);
        send_frame(sta_a);
        check("R8 disabled rejects", {got_vld, got_acc}, 2'b10);
        set_mode(1'b1, 1'b0);
        send_frame(sta_a);
        check("R9 not valid one edge early", early_vld, 0);
        check("R2 station match accept", {got_vld, got_acc}, 2'b11);
        send_frame(oth_a);
        check("R2 mismatch reject", {got_vld, got_acc}, 2'b10);
    endtask

    task automatic t_hash;
        logic [63:0] t;
        t = 64'd0; t[i1] = 1'b1;
        load_table(t);
        set_mode(1'b1, 1'b0);
        send_frame(g1);
        check("R3 group bin set accept", {got_vld, got_acc}, 2'b11);
        send_frame(g2);
        check("R3 other group", {got_vld, got_acc}, {1'b1, i2 == i1});
        load_table(~t);
        set_mode(1'b1, 1'b0);
        send_frame(g1);
        check("R3 group bin clear reject", {got_vld, got_acc}, 2'b10);
    endtask

    task automatic t_allones;
        load_table({64{1'b1}});
        set_mode(1'b1, 1'b0);
        send_frame(g1);
        check("R10 all ones g1", {got_vld, got_acc}, 2'b11);
        send_frame(g2);
        check("R10 all ones g2", {got_vld, got_acc}, 2'b11);
        send_frame(oth_a);
        check("R10 individual still needs match", {got_vld, got_acc}, 2'b10);
    endtask

    task automatic t_ignore;
        cfg_write(T_CTRL, 8'h06);
        for (int k = 0; k < 6; k++) cfg_write(T_STA, 8'hAA);
        for (int k = 0; k < 8; k++) cfg_write(T_TBL, 8'h00);
        cfg_write(T_CTRL, 8'h00);
        check("R6 rx_en kept", rx_en, 1);
        send_frame(sta_a);
        check("R6 station untouched", {got_vld, got_acc}, 2'b11);
        send_frame(g1);
        check("R6 table untouched", {got_vld, got_acc}, 2'b11);
    endtask

    task automatic t_gating;
        cfg_write(T_CTRL, 8'h05);
        for (int k = 0; k < 8; k++) cfg_write(T_TBL, 8'h00);
        check("R4 table write needs reset bit, en kept", rx_en, 1);
        send_frame(g1);
        check("R4 table unchanged without reset bit", {got_vld, got_acc}, 2'b11);
        for (int k = 0; k < 3; k++) cfg_write(T_STA, 8'h55);
        cfg_write(T_CTRL, 8'h05);
        for (int k = 0; k < 6; k++) cfg_write(T_STA, sta_a[8*k +: 8]);
        cfg_write(T_CTRL, 8'h00);
        set_mode(1'b1, 1'b0);
        send_frame(sta_a);
        check("R5 pointer reset reload", {got_vld, got_acc}, 2'b11);
        cfg_write(T_CTRL, 8'h03);
        cfg_write(T_TBL, 8'hFF);
        cfg_write(T_TBL, 8'hFF);
        cfg_write(T_CTRL, 8'h03);
        for (int k = 0; k < 8; k++) cfg_write(T_TBL, 8'h00);
        cfg_write(T_CTRL, 8'h00);
        set_mode(1'b1, 1'b0);
        send_frame(g1);
        check("R4 pointer reset clears table", {got_vld, got_acc}, 2'b10);
    endtask

    task automatic t_promisc;
        set_mode(1'b1, 1'b1);
        check("R8 promisc change clears en", rx_en, 0);
        send_frame(oth_a);
        check("R8 disabled in promisc rejects", {got_vld, got_acc}, 2'b10);
        set_mode(1'b1, 1'b1);
        send_frame(oth_a);
        check("R7 promisc individual", {got_vld, got_acc}, 2'b11);
        send_frame(g1);
        check("R7 promisc group empty table", {got_vld, got_acc}, 2'b11);
        set_mode(1'b1, 1'b0);
        check("R8 promisc off clears en", rx_en, 0);
        set_mode(1'b1, 1'b0);
        send_frame(oth_a);
        check("R2 back to filtering", {got_vld, got_acc}, 2'b10);
    endtask

    task automatic t_hold;
        send_frame(sta_a);
        repeat (5) @(negedge clk);
        check("R9 result held", {acc_valid, acc}, 2'b11);
        da_valid = 1'b1; da_first = 1'b1; da_byte = sta_a[7:0];
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0;
        check("R9 cleared by frame start", acc_valid, 0);
    endtask

    initial begin
        sta_a = mac(8'h08, 8'h00, 8'h20, 8'h12, 8'h34, 8'h56);
        oth_a = mac(8'h08, 8'h00, 8'h20, 8'h12, 8'h34, 8'h57);
        g1    = mac(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
        g2    = mac(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hFB);
        i1 = hash_idx(g1);
        i2 = hash_idx(g2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_station();
        t_hash();
        t_allones();
        t_ignore();
        t_gating();
        t_promisc();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule